// File: doc/BRIEF.md
# Boot Isolation Level Controller

This block keeps the temporal isolation level of a staged secure boot chain and guards one protected flash region against later stages. The level is a two-bit counter that can only move upward while the chip runs. Level 0 belongs to system code, level 1 to the immutable root of trust, level 2 to the updatable root of trust, and level 3 to the final application. Once the boot chain has finished, the device sits at level 3. Only a reset brings the level back to 0.

Each stage hands over to the next by pulsing an increment request, or by writing a higher target level. Any write that would keep the level the same or lower it is dropped. The protected region is a span of sectors between an inclusive low bound and an inclusive high bound. The bounds can be written only while the level is 0. A sector lookup gives a combinational allow or deny answer. Sectors inside the region are denied once the level is above the level that owns the region.

Top module: `boot_iso_level`

## Requirements
- R1: After reset the level output is 0, the saturation flag is 0, and the region is empty: low bound all ones, high bound 0, so every sector is allowed.
- R2: An increment request while the level is below 3, with no accepted level write in the same cycle, raises the level by exactly one. The new level is visible on the output one cycle after the request.
- R3: An increment request at level 3 leaves the level at 3 and sets the saturation flag. The flag stays set until the next reset.
- R4: A level write (binary encoding, 0 to 3) is accepted only if its value is greater than the current level. An accepted write sets the level to that value on the next cycle. A write of an equal or lower value has no effect.
- R5: A bound write with select 0 loads the low bound, and with select 1 loads the high bound. The write takes effect only while the level is 0. At any other level it is ignored.
- R6: While the level is above OWNER_LEVEL (default 1), a sector with low ≤ sector ≤ high is denied (allow = 0). Both ends are inclusive.
- R7: While the level is at or below OWNER_LEVEL, every sector is allowed.
- R8: A sector outside the bounds is always allowed, at every level.
- R9: If the low bound is greater than the high bound, the region is empty and no sector is denied.
- R10: When an accepted level write and an increment request arrive in the same cycle, the write wins and the increment is discarded. It neither adds a step nor sets the saturation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the only way back to level 0 |
| incReq | input | 1 | Pulse to raise the level by one |
| lvlWrEn | input | 1 | Level write strobe |
| lvlWrVal | input | LVL_W | Target level for a level write |
| cfgWrEn | input | 1 | Bound write strobe |
| cfgSel | input | 1 | 0 selects the low bound, 1 selects the high bound |
| cfgData | input | SECTOR_W | Bound value to write |
| accSector | input | SECTOR_W | Sector number to look up |
| curLevel | output | LVL_W | Current isolation level |
| satErr | output | 1 | Sticky flag for an increment requested at the top level |
| accAllow | output | 1 | 1 when an access to accSector is allowed |

## Verification
Directed sequences first walk the level from 0 to 3 with a region of sectors 10 to 20 in place. At each level they probe sectors at both inclusive edges and one step outside them, which separates an off-by-one bound comparison from a wrong level threshold. Further directed cases try lowering and equal level writes, bound writes at a non-zero level, a write and an increment in the same cycle, and an inverted region. These show the difference between dropping a request and acting on it. A seeded random phase then mixes increments, level writes, bound writes, sector lookups and occasional resets. It compares every cycle against a bench model, which exposes ordering and priority faults that single directed steps would miss.

// File: rtl/iso_level_pkg.sv
package iso_level_pkg;
  // strobes from the level control to the region datapath
  typedef struct packed {
    logic wrLow;       // load low bound this cycle
    logic wrHigh;      // load high bound this cycle
    logic denyActive;  // level is above the owning level
  } isoStrobe_t;
endpackage

// File: rtl/iso_level_ctrl_unit.sv
module iso_level_ctrl_unit
  import iso_level_pkg::*;
#(
  parameter int LVL_W       = 2,
  parameter int OWNER_LEVEL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             incReq,
  input  logic             lvlWrEn,
  input  logic [LVL_W-1:0] lvlWrVal,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  output logic [LVL_W-1:0] level,
  output logic             satErr,
  output isoStrobe_t       strobe
);
  localparam logic [LVL_W-1:0] TOP_LVL   = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] OWNER_LVL = LVL_W'(OWNER_LEVEL);

  logic             wrRaise;
  logic             atTop;
  logic [LVL_W-1:0] levelNext;
  logic             satNext;

  assign wrRaise = lvlWrEn && (lvlWrVal > level);
  assign atTop   = (level == TOP_LVL);

  always_comb begin
    levelNext = level;
    satNext   = satErr;
    if (wrRaise) begin
      levelNext = lvlWrVal;
    end else if (incReq) begin
      if (atTop) satNext = 1'b1;
      else       levelNext = level + LVL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= '0;
      satErr <= 1'b0;
    end else begin
      level  <= levelNext;
      satErr <= satNext;
    end
  end

  always_comb begin
    strobe.wrLow      = cfgWrEn && !cfgSel && (level == '0);
    strobe.wrHigh     = cfgWrEn &&  cfgSel && (level == '0);
    strobe.denyActive = (level > OWNER_LVL);
  end
endmodule

// File: rtl/iso_region_dp.sv
module iso_region_dp
  import iso_level_pkg::*;
#(
  parameter int SECTOR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  isoStrobe_t          strobe,
  input  logic [SECTOR_W-1:0] cfgData,
  input  logic [SECTOR_W-1:0] accSector,
  output logic [SECTOR_W-1:0] lowBound,
  output logic [SECTOR_W-1:0] highBound,
  output logic                accAllow
);
  logic aboveLow;
  logic belowHigh;
  logic inRegion;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowBound  <= '1;
      highBound <= '0;
    end else begin
      if (strobe.wrLow)  lowBound  <= cfgData;
      if (strobe.wrHigh) highBound <= cfgData;
    end
  end

  // an inverted pair can never satisfy both compares, so it is empty
  assign aboveLow  = (accSector >= lowBound);
  assign belowHigh = (accSector <= highBound);
  assign inRegion  = aboveLow && belowHigh;
  assign accAllow  = !(inRegion && strobe.denyActive);
endmodule

// File: rtl/boot_iso_level.sv
module boot_iso_level
  import iso_level_pkg::*;
#(
  parameter int LVL_W       = 2,
  parameter int SECTOR_W    = 8,
  parameter int OWNER_LEVEL = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                incReq,
  input  logic                lvlWrEn,
  input  logic [LVL_W-1:0]    lvlWrVal,
  input  logic                cfgWrEn,
  input  logic                cfgSel,
  input  logic [SECTOR_W-1:0] cfgData,
  input  logic [SECTOR_W-1:0] accSector,
  output logic [LVL_W-1:0]    curLevel,
  output logic                satErr,
  output logic                accAllow
);
  isoStrobe_t          strobe;
  logic [SECTOR_W-1:0] lowBound;
  logic [SECTOR_W-1:0] highBound;

  iso_level_ctrl_unit #(.LVL_W(LVL_W), .OWNER_LEVEL(OWNER_LEVEL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .incReq(incReq), .lvlWrEn(lvlWrEn),
    .lvlWrVal(lvlWrVal), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .level(curLevel), .satErr(satErr), .strobe(strobe)
  );

  iso_region_dp #(.SECTOR_W(SECTOR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cfgData(cfgData),
    .accSector(accSector), .lowBound(lowBound), .highBound(highBound),
    .accAllow(accAllow)
  );
endmodule

// File: rtl/boot_iso_level_chk.sv
module boot_iso_level_chk #(
  parameter int LVL_W       = 2,
  parameter int SECTOR_W    = 8,
  parameter int OWNER_LEVEL = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                incReq,
  input logic                lvlWrEn,
  input logic [LVL_W-1:0]    lvlWrVal,
  input logic [SECTOR_W-1:0] accSector,
  input logic [LVL_W-1:0]    curLevel,
  input logic                satErr,
  input logic                accAllow,
  input logic [SECTOR_W-1:0] lowBound,
  input logic [SECTOR_W-1:0] highBound
);
  localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

  p_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    curLevel >= $past(curLevel));

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (incReq && !lvlWrEn && curLevel != TOP_LVL) |=> (curLevel == $past(curLevel) + LVL_W'(1)));

  p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (incReq && !lvlWrEn && curLevel == TOP_LVL) |=> (satErr && curLevel == TOP_LVL));

  p_sticky_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    satErr |=> satErr);

  p_bounds_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (curLevel != '0) |=> ($stable(lowBound) && $stable(highBound)));

  p_outside_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accSector < lowBound || accSector > highBound) |-> accAllow);

  p_owner_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (curLevel <= LVL_W'(OWNER_LEVEL)) |-> accAllow);
endmodule

bind boot_iso_level boot_iso_level_chk #(
  .LVL_W(LVL_W), .SECTOR_W(SECTOR_W), .OWNER_LEVEL(OWNER_LEVEL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .incReq(incReq), .lvlWrEn(lvlWrEn),
  .lvlWrVal(lvlWrVal), .accSector(accSector), .curLevel(curLevel),
  .satErr(satErr), .accAllow(accAllow), .lowBound(lowBound),
  .highBound(highBound)
);

// File: tb/boot_iso_level_tb.sv
module boot_iso_level_tb;
  localparam int LW = 2;
  localparam int SW = 8;
  localparam int OWN = 1;

  logic clk = 0;
  logic rst_n = 0;
  logic incReq = 0, lvlWrEn = 0, cfgWrEn = 0, cfgSel = 0;
  logic [LW-1:0] lvlWrVal = '0;
  logic [SW-1:0] cfgData = '0, accSector = '0;
  logic [LW-1:0] curLevel;
  logic satErr, accAllow;

  int total = 0, bad = 0;
  int mLevel = 0, mLow = 255, mHigh = 0;
  bit mErr = 0;

  always #5 clk = ~clk;

  boot_iso_level #(.LVL_W(LW), .SECTOR_W(SW), .OWNER_LEVEL(OWN)) u_dut (
    .clk(clk), .rst_n(rst_n), .incReq(incReq), .lvlWrEn(lvlWrEn),
    .lvlWrVal(lvlWrVal), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .accSector(accSector), .curLevel(curLevel),
    .satErr(satErr), .accAllow(accAllow)
  );

  function automatic bit expAllow(int sec);
    return !(sec >= mLow && sec <= mHigh && mLevel > OWN);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 0; incReq = 0; lvlWrEn = 0; cfgWrEn = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mLevel = 0; mLow = 255; mHigh = 0; mErr = 0;
  endtask

  // apply inputs at negedge, advance one edge, update model, check state
  task automatic step(bit inc, bit we, int wv, bit ce, bit cs, int cd, string tag);
    @(negedge clk);
    incReq = inc; lvlWrEn = we; lvlWrVal = LW'(wv);
    cfgWrEn = ce; cfgSel = cs; cfgData = SW'(cd);
    @(posedge clk);
    if (ce && mLevel == 0) begin
      if (cs) mHigh = cd; else mLow = cd;
    end
    if (we && wv > mLevel) mLevel = wv;
    else if (inc) begin
      if (mLevel == 3) mErr = 1; else mLevel = mLevel + 1;
    end
    #1;
    chk(curLevel == LW'(mLevel), tag, int'(curLevel), mLevel);
    chk(satErr == mErr, tag, int'(satErr), int'(mErr));
    @(negedge clk);
    incReq = 0; lvlWrEn = 0; cfgWrEn = 0;
  endtask

  task automatic probe(int sec, string tag);
    accSector = SW'(sec);
    #1;
    chk(accAllow == expAllow(sec), tag, int'(accAllow), int'(expAllow(sec)));
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    doReset();
    @(negedge clk);
    // R1 reset state
    chk(curLevel == 0, "R1 level", int'(curLevel), 0);
    chk(satErr == 0, "R1 err", int'(satErr), 0);
    probe(0, "R1"); probe(255, "R1");
    // R5 bounds at level 0
    step(0, 0, 0, 1, 0, 10, "R5");
    step(0, 0, 0, 1, 1, 20, "R5");
    step(1, 0, 0, 0, 0, 0, "R2 0->1");
    probe(15, "R7"); probe(10, "R7");
    step(1, 0, 0, 0, 0, 0, "R2 1->2");
    probe(10, "R6 low edge"); probe(20, "R6 high edge"); probe(15, "R6");
    probe(9, "R8"); probe(21, "R8");
    // R5 write at level 2 ignored: region stays 10..20
    step(0, 0, 0, 1, 0, 0, "R5 ignored");
    probe(5, "R5 low kept"); probe(10, "R5 low kept");
    // R4 lower/equal write ignored, higher accepted
    step(0, 1, 1, 0, 0, 0, "R4 lower");
    step(0, 1, 2, 0, 0, 0, "R4 equal");
    step(0, 1, 3, 0, 0, 0, "R4 raise");
    probe(12, "R6 lvl3");
    // R3 saturation and stickiness
    step(1, 0, 0, 0, 0, 0, "R3 sat");
    step(0, 0, 0, 0, 0, 0, "R3 sticky");
    // R9 inverted region
    doReset();
    step(0, 0, 0, 1, 0, 30, "R9");
    step(0, 0, 0, 1, 1, 5, "R9");
    step(0, 1, 3, 0, 0, 0, "R9 raise");
    probe(5, "R9"); probe(17, "R9"); probe(30, "R9");
    // R10 write wins over increment
    doReset();
    step(1, 1, 2, 0, 0, 0, "R10 write wins");
    step(1, 1, 3, 0, 0, 0, "R10 no step");
    step(1, 0, 0, 0, 0, 0, "R3 after R10");
    // random phase
    doReset();
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(199) == 0) doReset();
      step(($urandom_range(3) == 0), ($urandom_range(5) == 0), $urandom_range(3),
           ($urandom_range(2) == 0), $urandom_range(1), $urandom_range(63), "R2 R4 R5 rand");
      probe($urandom_range(63), "R6 R8 rand");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule